// File: doc/BRIEF.md
# Receiver Tracking-Loop Hold Controller

This block decides when a receiver's gain-control, frequency-correction and detector-threshold loops must stop adapting. It produces one registered hold signal that the loops use as a freeze input. A status copy of the same hold goes to whatever qualifies frequency-correction readings, because those readings only mean something while the loops are held.

Software selects one of four hold policies through a 2-bit mode field. The block also takes a single-cycle pulse from the sync-word detector and a single-cycle strobe for every received byte. In the timed policy, a down-counter loads a programmed byte count when the sync pulse arrives and counts strobes until the hold is released. The tracking loops and sync detection themselves sit outside this block.

Top module: `rx_hold_ctrl`

## Requirements
- R1: With mode 0 (free-running) sampled and unchanged, the hold output is low after that clock edge, whatever the sync and byte inputs do.
- R2: With mode 1 (sync-latched), a sync pulse sampled while unlocked raises the hold on that edge. The hold then stays high, ignoring byte strobes, until a different mode is sampled.
- R3: With mode 2 (sync-timed) and a byte limit N greater than 0, a sync pulse sampled while unlocked raises the hold and loads N. Each later sampled byte strobe counts down by one. The hold falls on the edge that samples the Nth strobe. A strobe in the same cycle as the locking sync pulse is not counted, and cycles without a strobe do not count.
- R4: With mode 3 (forced), the hold is high after the first edge that samples mode 3, with no sync pulse needed.
- R5: The status output always equals the hold output.
- R6: In mode 2 with a byte limit of 0, a sync pulse never raises the hold.
- R7: On the edge that samples a mode value different from the previous one, the hold is cleared (set if the new mode is 3) and the byte counter is reset. A sync pulse in that same cycle is ignored.
- R8: A sync pulse sampled while already locked in mode 1 or mode 2 has no effect. In mode 2 it does not reload the byte count.
- R9: After a timed hold expires in mode 2, the next sync pulse locks again with a freshly loaded count.
- R10: Synchronous active-high reset clears the hold and takes the previous mode as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Hold policy: 0 free, 1 sync-latched, 2 sync-timed, 3 forced |
| byte_limit_i | input | CNT_W | Byte count for the sync-timed policy |
| sync_pulse_i | input | 1 | Valid sync word detected (one cycle) |
| byte_strobe_i | input | 1 | One received byte (one cycle) |
| hold_o | output | 1 | Freeze for the tracking loops |
| hold_status_o | output | 1 | Hold-active status for readback qualification |

## Verification
Each policy is driven with sync pulses and byte strobes that arrive in different orders. Sync pulses that arrive before arming, on the mode-change edge, or while already locked show whether the block accepts sync only from the unlocked state. Timed locks with limits of 1, 3 and 5, with idle gaps between strobes and a strobe that coincides with the sync pulse, show whether the count is exact and whether the block reloads the count when it should not. Mode changes in the middle of a lock show whether the block clears the hold and resets the counter.

// File: rtl/rx_hold_pkg.sv
package rx_hold_pkg;
    typedef enum logic [1:0] {
        HOLD_FREE  = 2'd0,
        HOLD_LATCH = 2'd1,
        HOLD_TIMED = 2'd2,
        HOLD_FORCE = 2'd3
    } hold_mode_e;

    typedef struct packed {
        logic clr;
        logic load;
        logic dec;
    } cnt_ctl_t;

    function automatic logic mode_needs_sync(input hold_mode_e m);
        return (m == HOLD_LATCH) || (m == HOLD_TIMED);
    endfunction
endpackage

// File: rtl/rx_hold_mode_track.sv
module rx_hold_mode_track
    import rx_hold_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_i,
    output hold_mode_e mode_cur,
    output logic       mode_chg
);
    hold_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= HOLD_FREE;
        else     mode_q <= hold_mode_e'(mode_i);
    end

    assign mode_cur = hold_mode_e'(mode_i);
    assign mode_chg = (mode_i != mode_q);
endmodule

// File: rtl/rx_hold_counter.sv
module rx_hold_counter
    import rx_hold_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctl_t         ctl,
    input  logic [CNT_W-1:0] load_val,
    output logic             cnt_last,
    output logic             cnt_nz
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || ctl.clr)     cnt_q <= '0;
        else if (ctl.load)      cnt_q <= load_val;
        else if (ctl.dec && cnt_q != '0) cnt_q <= cnt_q - ONE;
    end

    assign cnt_last = (cnt_q == ONE);
    assign cnt_nz   = (cnt_q != '0);

    // R3
    cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.load && !ctl.clr) |=> (cnt_q == $past(load_val)));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.dec && !ctl.clr && !ctl.load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/rx_hold_fsm.sv
module rx_hold_fsm
    import rx_hold_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  hold_mode_e       mode_cur,
    input  logic             mode_chg,
    input  logic             sync_pulse,
    input  logic             byte_strobe,
    input  logic [CNT_W-1:0] byte_limit,
    input  logic             cnt_last,
    input  logic             cnt_nz,
    output cnt_ctl_t         ctl,
    output logic             hold
);
    logic hold_q, hold_d, expire, limit_ok;

    assign limit_ok = (byte_limit != '0);
    assign expire   = ctl.dec && cnt_last;

    always_comb begin
        ctl.load = !mode_chg && mode_cur == HOLD_TIMED && !hold_q && sync_pulse && limit_ok;
        ctl.dec  = !mode_chg && mode_cur == HOLD_TIMED && hold_q && byte_strobe;
        ctl.clr  = mode_chg || mode_cur != HOLD_TIMED || expire;
    end

    always_comb begin
        if (mode_chg) begin
            hold_d = (mode_cur == HOLD_FORCE);
        end else begin
            unique case (mode_cur)
                HOLD_FREE:  hold_d = 1'b0;
                HOLD_FORCE: hold_d = 1'b1;
                HOLD_LATCH: hold_d = hold_q || sync_pulse;
                HOLD_TIMED: hold_d = hold_q ? !expire : (sync_pulse && limit_ok);
                default:    hold_d = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hold_q <= 1'b0;
        else     hold_q <= hold_d;
    end

    assign hold = hold_q;

    // R1
    free_release_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_cur == HOLD_FREE) |=> !hold_q);

    // R4
    force_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_cur == HOLD_FORCE) |=> hold_q);

    // R2
    latch_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_q && mode_cur == HOLD_LATCH && !mode_chg) |=> hold_q);

    // R7
    change_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_chg && mode_cur != HOLD_FORCE) |=> !hold_q);

    // R6
    zero_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_cur == HOLD_TIMED && !limit_ok && !hold_q) |=> !hold_q);

    // R3
    timed_count_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_q && mode_cur == HOLD_TIMED && !mode_chg) |-> cnt_nz);
endmodule

// File: rtl/rx_hold_ctrl.sv
module rx_hold_ctrl
    import rx_hold_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] byte_limit_i,
    input  logic             sync_pulse_i,
    input  logic             byte_strobe_i,
    output logic             hold_o,
    output logic             hold_status_o
);
    hold_mode_e mode_cur;
    logic       mode_chg, cnt_last, cnt_nz, hold;
    cnt_ctl_t   ctl;

    rx_hold_mode_track u_mode (
        .clk(clk), .rst(rst), .mode_i(mode_i),
        .mode_cur(mode_cur), .mode_chg(mode_chg)
    );

    rx_hold_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .ctl(ctl), .load_val(byte_limit_i),
        .cnt_last(cnt_last), .cnt_nz(cnt_nz)
    );

    rx_hold_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst(rst), .mode_cur(mode_cur), .mode_chg(mode_chg),
        .sync_pulse(sync_pulse_i), .byte_strobe(byte_strobe_i),
        .byte_limit(byte_limit_i), .cnt_last(cnt_last), .cnt_nz(cnt_nz),
        .ctl(ctl), .hold(hold)
    );

    assign hold_o        = hold;
    assign hold_status_o = hold;

    // R10
    reset_clear_chk: assert property (@(posedge clk) rst |=> !hold_o);
endmodule

// File: tb/rx_hold_ctrl_bench.sv
module rx_hold_ctrl_bench;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       mode = 2'd0;
    logic [CNT_W-1:0] limit = '0;
    logic             sync = 1'b0;
    logic             strobe = 1'b0;
    logic             hold_o, hold_status_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rx_hold_ctrl #(.CNT_W(CNT_W)) u_rx_hold_ctrl (
        .clk(clk), .rst(rst), .mode_i(mode), .byte_limit_i(limit),
        .sync_pulse_i(sync), .byte_strobe_i(strobe),
        .hold_o(hold_o), .hold_status_o(hold_status_o)
    );

    task automatic step(input logic [1:0] m, input logic s, input logic b);
        mode = m; sync = s; strobe = b;
        @(posedge clk); #1;
        sync = 1'b0; strobe = 1'b0;
    endtask

    task automatic expect_hold(input logic exp, input string tag);
        checks++;
        if (hold_o !== exp) begin
            errors++;
            $display("FAIL %s hold actual %b expected %b", tag, hold_o, exp);
        end
        checks++;
        if (hold_status_o !== hold_o) begin
            errors++;
            $display("FAIL R5 status actual %b expected %b", hold_status_o, hold_o);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; mode = 2'd3;
        repeat (3) @(posedge clk);
        #1; expect_hold(1'b0, "R10");
        rst = 1'b0; mode = 2'd0;
        step(2'd0, 1'b0, 1'b0); expect_hold(1'b0, "R10");
    endtask

    task automatic t_free();
        step(2'd0, 1'b1, 1'b0); expect_hold(1'b0, "R1");
        step(2'd0, 1'b1, 1'b1); expect_hold(1'b0, "R1");
    endtask

    task automatic t_force();
        step(2'd3, 1'b0, 1'b0); expect_hold(1'b1, "R4");
        step(2'd3, 1'b0, 1'b1); expect_hold(1'b1, "R4");
        step(2'd0, 1'b0, 1'b0); expect_hold(1'b0, "R7");
    endtask

    task automatic t_latch();
        step(2'd1, 1'b1, 1'b0); expect_hold(1'b0, "R7 sync on change edge");
        step(2'd1, 1'b0, 1'b0); expect_hold(1'b0, "R2 armed");
        step(2'd1, 1'b1, 1'b0); expect_hold(1'b1, "R2 lock");
        for (int i = 0; i < 5; i++) step(2'd1, 1'b0, 1'b1);
        expect_hold(1'b1, "R2 strobes ignored");
        step(2'd1, 1'b1, 1'b0); expect_hold(1'b1, "R8 latch");
        step(2'd0, 1'b0, 1'b0); expect_hold(1'b0, "R7 release");
    endtask

    task automatic t_timed();
        limit = 8'd3;
        step(2'd2, 1'b0, 1'b0); expect_hold(1'b0, "R3 armed");
        step(2'd2, 1'b1, 1'b0); expect_hold(1'b1, "R3 lock");
        step(2'd2, 1'b0, 1'b1); expect_hold(1'b1, "R3 byte1");
        step(2'd2, 1'b0, 1'b0); expect_hold(1'b1, "R3 idle");
        step(2'd2, 1'b0, 1'b1); expect_hold(1'b1, "R3 byte2");
        step(2'd2, 1'b1, 1'b0); expect_hold(1'b1, "R8 timed");
        step(2'd2, 1'b0, 1'b1); expect_hold(1'b0, "R8 no reload, R3 byte3");
        step(2'd2, 1'b1, 1'b1); expect_hold(1'b1, "R9 relock");
        step(2'd2, 1'b0, 1'b1); step(2'd2, 1'b0, 1'b1);
        expect_hold(1'b1, "R3 coincident strobe not counted");
        step(2'd2, 1'b0, 1'b1); expect_hold(1'b0, "R9 expire");
        limit = 8'd1;
        step(2'd2, 1'b1, 1'b0); expect_hold(1'b1, "R3 limit1 lock");
        step(2'd2, 1'b0, 1'b1); expect_hold(1'b0, "R3 limit1 expire");
    endtask

    task automatic t_zero();
        limit = 8'd0;
        step(2'd2, 1'b1, 1'b0); expect_hold(1'b0, "R6");
        step(2'd2, 1'b1, 1'b1); expect_hold(1'b0, "R6");
    endtask

    task automatic t_change();
        limit = 8'd5;
        step(2'd2, 1'b1, 1'b0); expect_hold(1'b1, "R3 lock5");
        step(2'd2, 1'b0, 1'b1);
        step(2'd1, 1'b0, 1'b0); expect_hold(1'b0, "R7 mid-lock");
        step(2'd2, 1'b0, 1'b0); expect_hold(1'b0, "R7 back");
        step(2'd2, 1'b1, 1'b0); expect_hold(1'b1, "R7 relock");
        for (int i = 0; i < 4; i++) step(2'd2, 1'b0, 1'b1);
        expect_hold(1'b1, "R7 counter reset");
        step(2'd2, 1'b0, 1'b1); expect_hold(1'b0, "R3 fifth byte");
        step(2'd2, 1'b1, 1'b0);
        step(2'd3, 1'b0, 1'b0); expect_hold(1'b1, "R7 to forced");
    endtask

    initial begin
        t_reset();
        t_free();
        t_force();
        t_latch();
        t_timed();
        t_zero();
        t_change();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule